// File: doc/BRIEF.md
# ATAPI Packet Device Interface Controller

This block is the device side of a packet-protocol disk interface. A host reaches it through a small register bus. The host writes a packet command and then pushes a 12-byte command packet through the 16-bit data port. The block hands that packet to an external command executor, which it does not contain. While the block is busy, the executor fills an internal word buffer. It then either reports a result code or launches a response. The block streams the response to the host word by word, using programmed reads with an interrupt at each block boundary, or using DMA bursts that an external DMA engine requests. Throughout, it maintains the status byte, the interrupt-reason byte, the byte-count pair, the error byte, the sense bytes and the interrupt line.

The control is one state machine with six states:
- `ST_IDLE` moves to `ST_PKT_IN` when the host writes the packet command.
- `ST_PKT_IN` moves to `ST_BUSY` on the sixth data word.
- `ST_BUSY` returns to `ST_IDLE` when a result is reported. A response start moves it to `ST_PIO_OUT` or `ST_DMA_OUT`, as selected by feature bit 0.
- `ST_PIO_OUT` returns to `ST_IDLE` when the last byte is read.
- `ST_DMA_OUT` moves to `ST_DMA_XFER` when it accepts a request with a nonzero clamped length.
- `ST_DMA_XFER` goes back to `ST_DMA_OUT` after the burst, or to `ST_IDLE` when the response is used up.

Register addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | data |
| 1 | error (read) / feature (write) |
| 2 | interrupt reason |
| 4 | byte count low |
| 5 | byte count high |
| 7 | status (read) / command (write) |

Status bits are BSY=0x80, DRDY=0x40, SERV=0x10, DRQ=0x08 and CHK=0x01. Interrupt-reason bits are command/data=0x01 and I/O=0x02.

Top module: `atapi_pkt_ctrl`

## Requirements
- R1: After reset, status, error and interrupt reason read 0x00, `irq` is low, and the state is idle.
- R2: Writing 0xA0 to the command register while idle sets status to 0x48 and interrupt reason to 0x01, and copies feature bits [1:0] into the error register.
- R3: In packet-receive, each data-port write stores one word; word k lands in `pkt_data[16k+15:16k]`. On the sixth write, status becomes 0xC0 and `pkt_valid` pulses for one cycle.
- R4: In busy (with no `res_valid`), `rsp_start` sets status to 0x48 and interrupt reason to 0x02. Feature bit 0 = 1 selects DMA-out. Otherwise PIO-out is selected and the byte-count low/high registers load `rsp_len[7:0]` and `rsp_len[15:8]`.
- R5: In PIO-out, each data-port read returns the next buffer word, starting at word 0.
- R6: In PIO-out, a read that reaches the total length returns to idle, clears DRQ (status 0x40) and raises `irq`. Any other read that empties the block count raises `irq` and reloads the block count from the block size.
- R7: Reading the data port outside PIO-out returns 0xFFFF and changes neither status nor `irq`.
- R8: A DMA request in DMA-out is answered one cycle later by `dma_ack`, with `dma_count` equal to the smaller of the request length with bit 0 cleared and the bytes remaining. The burst then presents `dma_count/2` consecutive buffer words, one per cycle on `dma_wvalid`.
- R9: A DMA burst that exhausts the response returns to idle, clears DRQ and raises `irq`. A request outside DMA-out is acknowledged with count 0.
- R10: Reading status clears a pending `irq` only when BSY is clear.
- R11: A nonzero `res_code` in busy sets error[7:4] to code[3:0] and status to 0x51. It sets sense byte 0 to 0xF0, sense byte 2 to code[7:0] and sense byte 8 to code[15:8], where sense byte n is `sense_data[8n+7:8n]`. It also raises `irq` and returns to idle.
- R12: A zero `res_code` in busy clears BSY and CHK, raises `irq` and returns to idle.
- R13: A command write that is not 0xA0, or that arrives while not idle, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (read side effects) |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt to host |
| pkt_valid | output | 1 | One-cycle pulse: packet complete |
| pkt_data | output | 96 | Collected command packet |
| buf_wr_en | input | 1 | Executor buffer write (taken only in busy) |
| buf_wr_addr | input | AW | Executor buffer word address |
| buf_wr_data | input | 16 | Executor buffer word |
| rsp_start | input | 1 | Launch response |
| rsp_len | input | LEN_W | Response length in bytes |
| rsp_blk | input | LEN_W | PIO block size in bytes |
| res_valid | input | 1 | Result code valid |
| res_code | input | 16 | Result code |
| sense_data | output | 80 | Ten sense bytes |
| dma_req | input | 1 | DMA request pulse |
| dma_len | input | LEN_W | Requested DMA bytes |
| dma_ack | output | 1 | DMA request answered |
| dma_count | output | LEN_W | Bytes granted |
| dma_wvalid | output | 1 | DMA word valid |
| dma_wdata | output | 16 | DMA word |

## Verification
The bench builds the block with a 64-word buffer and 16-bit lengths. With this buffer, whole responses up to 128 bytes can be drawn at random and read to the end. This makes block sizes that equal, divide and do not divide the total all reachable within a short run. It also means DMA requests larger than the remainder routinely exercise the clamp.

// File: rtl/atapi_pkg.sv
package atapi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PKT_IN,
        ST_BUSY,
        ST_PIO_OUT,
        ST_DMA_OUT,
        ST_DMA_XFER
    } ctl_state_e;

    localparam logic [7:0] STS_BSY  = 8'h80;
    localparam logic [7:0] STS_DRDY = 8'h40;
    localparam logic [7:0] STS_SERV = 8'h10;
    localparam logic [7:0] STS_DRQ  = 8'h08;
    localparam logic [7:0] STS_CHK  = 8'h01;

    localparam logic [7:0] IR_COD = 8'h01;
    localparam logic [7:0] IR_IO  = 8'h02;

    localparam logic [2:0] RA_DATA    = 3'd0;
    localparam logic [2:0] RA_ERRFEAT = 3'd1;
    localparam logic [2:0] RA_IREASON = 3'd2;
    localparam logic [2:0] RA_BCL     = 3'd4;
    localparam logic [2:0] RA_BCH     = 3'd5;
    localparam logic [2:0] RA_STATCMD = 3'd7;

    localparam logic [7:0] CMD_PACKET = 8'hA0;
    localparam int PKT_WORDS   = 6;
    localparam int SENSE_BYTES = 10;
endpackage

// File: rtl/rsp_word_buf.sv
module rsp_word_buf #(
    parameter int WORDS = 2048,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/pkt_word_capture.sv
module pkt_word_capture #(
    parameter int NW = 6,
    localparam int IW = $clog2(NW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           wr,
    input  logic [15:0]    wdata,
    output logic [16*NW-1:0] pkt,
    output logic           last
);
    logic [IW-1:0] idx_q;

    assign last = wr && (idx_q == IW'(NW - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) idx_q <= '0;
        else if (wr)       idx_q <= last ? '0 : idx_q + 1'b1;
    end

    for (genvar i = 0; i < NW; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                          pkt[16*i +: 16] <= '0;
            else if (wr && idx_q == IW'(i))      pkt[16*i +: 16] <= wdata;
        end
    end
endmodule

// File: rtl/atapi_pkt_ctrl.sv
module atapi_pkt_ctrl
    import atapi_pkg::*;
#(
    parameter int BUF_WORDS = 2048,
    parameter int LEN_W = 16,
    localparam int AW = $clog2(BUF_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             irq,
    output logic             pkt_valid,
    output logic [95:0]      pkt_data,
    input  logic             buf_wr_en,
    input  logic [AW-1:0]    buf_wr_addr,
    input  logic [15:0]      buf_wr_data,
    input  logic             rsp_start,
    input  logic [LEN_W-1:0] rsp_len,
    input  logic [LEN_W-1:0] rsp_blk,
    input  logic             res_valid,
    input  logic [15:0]      res_code,
    output logic [79:0]      sense_data,
    input  logic             dma_req,
    input  logic [LEN_W-1:0] dma_len,
    output logic             dma_ack,
    output logic [LEN_W-1:0] dma_count,
    output logic             dma_wvalid,
    output logic [15:0]      dma_wdata
);
    localparam logic [LEN_W-1:0] EVEN_MASK = ~LEN_W'(1);

    ctl_state_e state_q, state_d;
    logic [7:0]       stat_q, err_q, irsn_q, bcl_q, bch_q;
    logic [1:0]       feat_q;
    logic [LEN_W-1:0] off_q, total_q, blk_len_q, blk_left_q, words_left_q;
    logic             irq_q;

    // host decode
    logic wr_cmd, wr_feat, wr_data, rd_data, rd_stat;
    assign wr_cmd  = reg_wr && reg_addr == RA_STATCMD;
    assign wr_feat = reg_wr && reg_addr == RA_ERRFEAT;
    assign wr_data = reg_wr && reg_addr == RA_DATA;
    assign rd_data = reg_rd && reg_addr == RA_DATA;
    assign rd_stat = reg_rd && reg_addr == RA_STATCMD;

    // packet capture
    logic cap_wr, pkt_last, pkt_go;
    assign pkt_go = wr_cmd && reg_wdata[7:0] == CMD_PACKET && state_q == ST_IDLE;
    assign cap_wr = wr_data && state_q == ST_PKT_IN;

    pkt_word_capture #(.NW(PKT_WORDS)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pkt_go),
        .wr    (cap_wr),
        .wdata (reg_wdata),
        .pkt   (pkt_data),
        .last  (pkt_last)
    );

    // response buffer
    logic [AW-1:0] ram_addr;
    logic [15:0]   ram_rdata;
    logic          ram_we;
    assign ram_we   = buf_wr_en && state_q == ST_BUSY;
    assign ram_addr = (state_q == ST_BUSY) ? buf_wr_addr : off_q[AW:1];

    rsp_word_buf #(.WORDS(BUF_WORDS)) u_buf (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (buf_wr_data),
        .rdata (ram_rdata)
    );

    // transfer events
    logic [LEN_W:0]   off_nx;
    logic [LEN_W-1:0] remaining, dma_even, dma_xfer;
    logic pio_rd, pio_end, blk_end, res_take, res_err, start_take;
    logic dma_take, xfer_last, dma_end, irq_set, irq_clr;

    assign off_nx     = {1'b0, off_q} + (LEN_W+1)'(2);
    assign remaining  = total_q - off_q;
    assign pio_rd     = rd_data && state_q == ST_PIO_OUT;
    assign pio_end    = pio_rd && off_nx >= {1'b0, total_q};
    assign blk_end    = pio_rd && !pio_end && blk_left_q <= LEN_W'(2);
    assign res_take   = res_valid && state_q == ST_BUSY;
    assign res_err    = res_take && res_code != 16'h0;
    assign start_take = rsp_start && state_q == ST_BUSY && !res_valid;
    assign dma_take   = dma_req && state_q == ST_DMA_OUT;
    assign dma_even   = dma_len & EVEN_MASK;
    assign dma_xfer   = (dma_even > remaining) ? remaining : dma_even;
    assign xfer_last  = state_q == ST_DMA_XFER && words_left_q == LEN_W'(1);
    assign dma_end    = xfer_last && off_nx >= {1'b0, total_q};
    assign irq_set    = pio_end || blk_end || dma_end || res_take;
    assign irq_clr    = rd_stat && !stat_q[7];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (pkt_go) state_d = ST_PKT_IN;
            ST_PKT_IN:   if (pkt_last) state_d = ST_BUSY;
            ST_BUSY: begin
                if (res_take)        state_d = ST_IDLE;
                else if (start_take) state_d = feat_q[0] ? ST_DMA_OUT : ST_PIO_OUT;
            end
            ST_PIO_OUT:  if (pio_end) state_d = ST_IDLE;
            ST_DMA_OUT:  if (dma_take && dma_xfer != '0) state_d = ST_DMA_XFER;
            ST_DMA_XFER: if (xfer_last) state_d = dma_end ? ST_IDLE : ST_DMA_OUT;
            default:     state_d = ST_IDLE;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0; err_q <= '0; irsn_q <= '0; feat_q <= '0;
            bcl_q <= '0; bch_q <= '0; off_q <= '0; total_q <= '0;
            blk_len_q <= '0; blk_left_q <= '0; words_left_q <= '0;
            irq_q <= 1'b0; pkt_valid <= 1'b0; dma_ack <= 1'b0;
            dma_count <= '0; sense_data <= '0;
        end else begin
            pkt_valid <= 1'b0;
            dma_ack   <= 1'b0;
            if (wr_feat) feat_q <= reg_wdata[1:0];
            if (reg_wr && reg_addr == RA_BCL) bcl_q <= reg_wdata[7:0];
            if (reg_wr && reg_addr == RA_BCH) bch_q <= reg_wdata[7:0];
            if (irq_set)      irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;

            if (pkt_go) begin
                stat_q <= STS_DRDY | STS_DRQ;
                irsn_q <= IR_COD;
                err_q  <= {6'b0, feat_q};
                off_q  <= '0;
            end
            if (pkt_last) begin
                stat_q    <= (stat_q & ~STS_DRQ) | STS_BSY;
                pkt_valid <= 1'b1;
            end
            if (res_err) begin
                err_q  <= {res_code[3:0], 4'b0};
                stat_q <= STS_DRDY | STS_SERV | STS_CHK;
                sense_data[7:0]   <= 8'hF0;
                sense_data[23:16] <= res_code[7:0];
                sense_data[71:64] <= res_code[15:8];
            end else if (res_take) begin
                stat_q <= stat_q & ~(STS_BSY | STS_CHK);
            end
            if (start_take) begin
                stat_q  <= STS_DRDY | STS_DRQ;
                irsn_q  <= IR_IO;
                total_q <= rsp_len & EVEN_MASK;
                off_q   <= '0;
                if (!feat_q[0]) begin
                    bcl_q      <= rsp_len[7:0];
                    bch_q      <= rsp_len[15:8];
                    blk_len_q  <= rsp_blk;
                    blk_left_q <= rsp_blk;
                end
            end
            if (pio_rd) begin
                off_q <= off_nx[LEN_W-1:0];
                if (pio_end) stat_q <= stat_q & ~STS_DRQ;
                if (blk_end) blk_left_q <= blk_len_q;
                else         blk_left_q <= blk_left_q - LEN_W'(2);
            end
            if (dma_req) begin
                dma_ack   <= 1'b1;
                dma_count <= dma_take ? dma_xfer : '0;
                if (dma_take) words_left_q <= dma_xfer >> 1;
            end
            if (state_q == ST_DMA_XFER) begin
                off_q        <= off_nx[LEN_W-1:0];
                words_left_q <= words_left_q - LEN_W'(1);
                if (dma_end) stat_q <= stat_q & ~STS_DRQ;
            end
        end
    end

    // host read mux
    always_comb begin
        unique case (reg_addr)
            RA_DATA:    reg_rdata = (state_q == ST_PIO_OUT) ? ram_rdata : 16'hFFFF;
            RA_ERRFEAT: reg_rdata = {8'h0, err_q};
            RA_IREASON: reg_rdata = {8'h0, irsn_q};
            RA_BCL:     reg_rdata = {8'h0, bcl_q};
            RA_BCH:     reg_rdata = {8'h0, bch_q};
            RA_STATCMD: reg_rdata = {8'h0, stat_q};
            default:    reg_rdata = 16'h0;
        endcase
    end

    assign irq        = irq_q;
    assign dma_wvalid = state_q == ST_DMA_XFER;
    assign dma_wdata  = ram_rdata;

    // R3
    pkt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> stat_q[7] && !stat_q[3]);
    // R6
    pio_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PIO_OUT |-> stat_q[3]);
    // R8
    dma_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack |-> dma_count <= $past(dma_len));
    // R9
    dma_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && state_q != ST_DMA_OUT |=> dma_ack && dma_count == '0);
    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_rd && reg_addr == RA_STATCMD));
    // R11
    res_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && state_q == ST_BUSY && res_code != 16'h0 |=>
        stat_q == 8'h51 && err_q[7:4] == $past(res_code[3:0]));
endmodule

// File: tb/atapi_pkt_ctrl_tb.sv
module atapi_pkt_ctrl_tb;
    localparam int BW = 64;
    localparam int LW = 16;
    localparam int AW = $clog2(BW);

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic irq, pkt_valid, dma_ack, dma_wvalid;
    logic [95:0] pkt_data;
    logic buf_wr_en = 0;
    logic [AW-1:0] buf_wr_addr = 0;
    logic [15:0] buf_wr_data = 0;
    logic rsp_start = 0, res_valid = 0, dma_req = 0;
    logic [LW-1:0] rsp_len = 0, rsp_blk = 0, dma_len = 0, dma_count;
    logic [15:0] res_code = 0, dma_wdata;
    logic [79:0] sense_data;

    int n_chk = 0, n_bad = 0;
    logic [15:0] exp_buf [BW];

    always #5 clk = ~clk;

    atapi_pkt_ctrl #(.BUF_WORDS(BW), .LEN_W(LW)) u_dut (.*);

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic send_packet(input logic [1:0] feat, input bit look);
        logic [15:0] v;
        logic [95:0] p;
        wr_reg(3'd1, {14'h0, feat});
        wr_reg(3'd7, 16'h00A0);
        if (look) begin
            rd_reg(3'd7, v); chk("R2 status", v, 16'h48);
            rd_reg(3'd2, v); chk("R2 ireason", v, 16'h01);
            rd_reg(3'd1, v); chk("R2 error", v, {14'h0, feat});
        end
        for (int k = 0; k < 6; k++) begin
            p[16*k +: 16] = 16'($urandom);
            wr_reg(3'd0, p[16*k +: 16]);
        end
        chk("R3 pkt_valid", pkt_valid, 1);
        chk("R3 pkt_data", pkt_data, p);
        @(negedge clk);
        chk("R3 pulse", pkt_valid, 0);
        if (look) begin
            rd_reg(3'd7, v); chk("R3 status busy", v, 16'hC0);
        end
    endtask

    task automatic fill_buf(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            exp_buf[i] = 16'($urandom);
            buf_wr_en = 1; buf_wr_addr = AW'(i); buf_wr_data = exp_buf[i];
        end
        @(negedge clk); buf_wr_en = 0;
    endtask

    task automatic start_rsp(input int len, input int blk, input bit dma);
        logic [15:0] v;
        @(negedge clk); rsp_start = 1; rsp_len = LW'(len); rsp_blk = LW'(blk);
        @(negedge clk); rsp_start = 0;
        rd_reg(3'd7, v); chk("R4 status", v, 16'h48);
        rd_reg(3'd2, v); chk("R4 ireason", v, 16'h02);
        if (!dma) begin
            rd_reg(3'd4, v); chk("R4 bcl", v, {8'h0, 8'(len)});
            rd_reg(3'd5, v); chk("R4 bch", v, {8'h0, 8'(len >> 8)});
        end
    endtask

    task automatic pio_run(input int len, input int blk, input bit clear_last);
        logic [15:0] v;
        int bl = blk;
        bit fin, be;
        for (int off = 0; off < len; off += 2) begin
            rd_reg(3'd0, v);
            chk("R5 pio word", v, exp_buf[off/2]);
            fin = (off + 2 >= len);
            be = !fin && bl <= 2;
            bl = be ? blk : bl - 2;
            chk("R6 irq", irq, fin || be);
            if ((fin || be) && (clear_last || !fin)) begin
                rd_reg(3'd7, v);
                chk("R6 status", v, fin ? 16'h40 : 16'h48);
                chk("R10 cleared", irq, 0);
            end
        end
    endtask

    task automatic dma_run(input int len);
        int off = 0;
        int req, x;
        logic [15:0] v;
        while (off < len) begin
            req = $urandom_range(0, 40);
            x = (req & ~1) > (len - off) ? (len - off) : (req & ~1);
            @(negedge clk); dma_req = 1; dma_len = LW'(req);
            @(negedge clk); dma_req = 0;
            chk("R8 ack", dma_ack, 1);
            chk("R8 count", dma_count, LW'(x));
            for (int k = 0; k < x / 2; k++) begin
                chk("R8 wvalid", dma_wvalid, 1);
                chk("R8 word", dma_wdata, exp_buf[off/2 + k]);
                @(negedge clk);
            end
            off += x;
            chk("R9 irq", irq, off >= len);
        end
        rd_reg(3'd7, v); chk("R9 status", v, 16'h40);
        chk("R10 cleared dma", irq, 0);
    endtask

    task automatic give_result(input logic [15:0] c);
        @(negedge clk); res_valid = 1; res_code = c;
        @(negedge clk); res_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int len, blk;
        void'($urandom(32'd4177));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        rd_reg(3'd7, v); chk("R1 status", v, 16'h00);
        rd_reg(3'd1, v); chk("R1 error", v, 16'h00);
        rd_reg(3'd2, v); chk("R1 ireason", v, 16'h00);
        chk("R1 irq", irq, 0);
        rd_reg(3'd0, v); chk("R1 R7 data idle", v, 16'hFFFF);
        // R13 unknown command ignored
        wr_reg(3'd7, 16'h0020);
        rd_reg(3'd7, v); chk("R13 bad cmd", v, 16'h00);
        rd_reg(3'd2, v); chk("R13 ireason", v, 16'h00);

        // directed PIO: block equal to total, then block dividing total
        send_packet(2'b10, 1);
        fill_buf(4); start_rsp(8, 8, 0); pio_run(8, 8, 1);
        send_packet(2'b00, 1);
        fill_buf(6); start_rsp(12, 4, 0); pio_run(12, 4, 1);

        // random PIO
        for (int it = 0; it < 6; it++) begin
            len = 2 * $urandom_range(1, BW);
            blk = 2 * $urandom_range(1, len / 2);
            send_packet({1'($urandom), 1'b0}, 1);
            fill_buf(len / 2);
            start_rsp(len, blk, 0);
            pio_run(len, blk, 1);
            rd_reg(3'd0, v); chk("R7 data after", v, 16'hFFFF);
            rd_reg(3'd7, v); chk("R7 status kept", v, 16'h40);
            chk("R7 irq kept", irq, 0);
        end

        // random DMA
        for (int it = 0; it < 4; it++) begin
            len = 2 * $urandom_range(1, BW);
            send_packet(2'b01, 1);
            fill_buf(len / 2);
            start_rsp(len, 2, 1);
            dma_run(len);
            @(negedge clk); dma_req = 1; dma_len = 16'd20;
            @(negedge clk); dma_req = 0;
            chk("R9 idle ack", dma_ack, 1);
            chk("R9 idle count", dma_count, 0);
        end

        // R13 command while busy; R10 irq held while BSY
        send_packet(2'b00, 1);
        fill_buf(1); start_rsp(2, 2, 0); pio_run(2, 2, 0);
        chk("R10 pending", irq, 1);
        send_packet(2'b00, 0);
        wr_reg(3'd7, 16'h00A0);
        rd_reg(3'd7, v); chk("R13 busy status", v, 16'hC0);
        chk("R10 kept while BSY", irq, 1);
        // R12
        give_result(16'h0000);
        rd_reg(3'd0, v); chk("R12 idle data", v, 16'hFFFF);
        chk("R12 irq", irq, 1);
        rd_reg(3'd7, v); chk("R12 status", v, 16'h40);
        chk("R10 cleared", irq, 0);
        // R11
        send_packet(2'b00, 1);
        give_result(16'h0A3B);
        chk("R11 irq", irq, 1);
        rd_reg(3'd1, v); chk("R11 error", v, 16'hB0);
        chk("R11 sense0", sense_data[7:0], 8'hF0);
        chk("R11 sense2", sense_data[23:16], 8'h3B);
        chk("R11 sense8", sense_data[71:64], 8'h0A);
        rd_reg(3'd7, v); chk("R11 status", v, 16'h51);
        rd_reg(3'd0, v); chk("R11 idle", v, 16'hFFFF);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule